// File: doc/BRIEF.md
# Event Counter Bank with Set/Clear Control

The block holds a bank of eight 64-bit counters behind a single-cycle 64-bit register port. Each counter has an 8-bit source selector. The selector either counts every clock or picks one strobe from a vector of single-cycle event pulses. A counter advances only when both the bank-wide run bit and its own run bit are set. Run bits and interrupt-enable bits are never written as whole words. Software changes them through a pair of registers per bitmap: one where a written 1 sets a bit, and one where a written 1 clears it.

When a counter rolls over from all ones to zero, its bit in a sticky overflow bitmap is set. Software clears that bitmap by writing ones. A level interrupt stays high while any overflowed counter also has its interrupt enabled. A system control word holds the bank-wide run bit and a strobe that zeroes every counter. Writes complete on the clock edge after they are presented. Reads are combinational from the address.

Top module: `evcnt_unit`

## Requirements
- R1: After reset the following all read zero: every counter, selector, per-counter control word, run bitmap, interrupt-enable bitmap, overflow bitmap and the system word. `irq_o` is low after reset.
- R2: Counter n is read and written as 64 bits at byte offset 0x000+8n, and a read returns its live value. Any other offset reads as zero, including offsets whose low three bits are nonzero and slots at n ≥ 8 in any region.
- R3: The selector of counter n is at 0x200+8n. Only bits [7:0] are stored, and the upper bits read zero. Code 0x00 counts every clock. Code k in 1..16 counts the cycles in which `events_i[k-1]` is high. Any other code never counts.
- R4: A counter increments only in a cycle where the system run bit (bit 0 of 0x400) is 1, its own run bit is 1, and its selected source is active.
- R5: A write to 0x410 sets the run bits where the data has ones. A write to 0x418 clears the run bits where the data has ones. Zero data bits leave a bit unchanged. Both offsets read back the run bitmap.
- R6: Interrupt-enable bits work the same way: ones written to 0x420 set them, ones written to 0x428 clear them, and both offsets read the bitmap.
- R7: Writing 0x400 with bit 1 set zeroes all counters at that edge. This takes priority over an increment in the same cycle, and run bit 0 is taken from the same write. Writing 0x400 with 0 stops all counting and keeps every counter value.
- R8: A counter that increments from all ones becomes zero, sets overflow bit n at the same edge, and keeps counting from zero.
- R9: Writing ones to the overflow bitmap at 0x440 clears exactly those bits. If a rollover and a clear of the same bit fall in one cycle, the bit ends up set.
- R10: `irq_o` is high exactly while the bitwise AND of the overflow bitmap and the interrupt-enable bitmap is nonzero.
- R11: The per-counter control word at 0x100+8n stores bits [7:0] and reads them back. Writing zero returns it to its reset value.
- R12: A direct counter write takes priority over an increment of the same counter in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, captured on the rising edge |
| addr_i | input | 12 | Byte offset of the register |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data for `addr_i`, combinational |
| events_i | input | 16 | Single-cycle event strobes |
| irq_o | output | 1 | Level interrupt |

## Verification
Two events can land on the same edge: a counter rolling over, which sets its overflow bit, and a software write that clears that bit. The bench arms a counter at all ones with its run bit set. It then turns the system run bit on and issues the clear on the very next write cycle, so both events fall on one edge. It then checks that the overflow bit reads back as set and that the counter went on from zero. The same timing method puts a direct counter write, and separately a bulk zeroing, on the same edge as an increment; each result is judged from the final count.

// File: rtl/evc_pkg.sv
package evc_pkg;
  // region nibble, addr[11:8]
  localparam logic [3:0] RGN_COUNT = 4'h0;
  localparam logic [3:0] RGN_CTRL  = 4'h1;
  localparam logic [3:0] RGN_SEL   = 4'h2;
  localparam logic [3:0] RGN_SYS   = 4'h4;
  // slots inside the system region, addr[7:3]
  localparam logic [4:0] SLOT_SYSW  = 5'd0;
  localparam logic [4:0] SLOT_RUNS  = 5'd2;
  localparam logic [4:0] SLOT_RUNC  = 5'd3;
  localparam logic [4:0] SLOT_IES   = 5'd4;
  localparam logic [4:0] SLOT_IEC   = 5'd5;
  localparam logic [4:0] SLOT_OVF   = 5'd8;
  localparam int SEL_W  = 8;
  localparam int CTRL_W = 8;
endpackage

// File: rtl/evc_bitmap.sv
module evc_bitmap #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;
  logic         q_ce;

  always_comb begin
    q_ce = (set_i != '0) || (clr_i != '0);
    q_d  = (q_o & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '0;
    else if (q_ce) q_o <= q_d;
  end

  // R5 / R9: a set request always lands
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));
  // R5 / R9: a clear without a competing set empties the bit
  a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i) != '0) |=> ((q_o & $past(clr_i & ~set_i)) == '0));
  // R5: zero request bits change nothing
  a_r5_quiet_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0 && clr_i == '0) |=> $stable(q_o));
endmodule

// File: rtl/evc_counter.sv
module evc_counter
  import evc_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int EV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_run_i,
  input  logic              run_i,
  input  logic              bulk_clr_i,
  input  logic [EV_W-1:0]   events_i,
  input  logic              wr_cnt_i,
  input  logic              wr_sel_i,
  input  logic              wr_ctrl_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              wrap_o
);
  logic             src_hit;
  logic             step;
  logic             cnt_ce;
  logic [CNT_W-1:0] cnt_d;

  // source selection: 0 = every clock, k = events_i[k-1]
  always_comb begin
    src_hit = (sel_o == '0);
    for (int k = 0; k < EV_W; k++) begin
      if (int'(sel_o) == k + 1) src_hit = events_i[k];
    end
  end

  always_comb begin
    step   = sys_run_i && run_i && src_hit;
    cnt_ce = bulk_clr_i || wr_cnt_i || step;
    if (bulk_clr_i)    cnt_d = '0;
    else if (wr_cnt_i) cnt_d = wdata_i;
    else               cnt_d = cnt_o + 1'b1;
    wrap_o = step && !bulk_clr_i && !wr_cnt_i && (cnt_o == '1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_o <= '0;
    else if (cnt_ce) cnt_o <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sel_o <= '0;
    else if (wr_sel_i) sel_o <= wdata_i[SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctrl_o <= '0;
    else if (wr_ctrl_i) ctrl_o <= wdata_i[CTRL_W-1:0];
  end

  a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_run_i && !wr_cnt_i && !bulk_clr_i) |=> $stable(cnt_o));
  a_r8_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_o == '0));
  a_r7_bulk_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bulk_clr_i |=> (cnt_o == '0));
  a_r12_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt_i && !bulk_clr_i) |=> (cnt_o == $past(wdata_i)));
endmodule

// File: rtl/evcnt_unit.sv
module evcnt_unit
  import evc_pkg::*;
#(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 64,
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 12,
  parameter int EV_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [EV_W-1:0]   events_i,
  output logic              irq_o
);
  localparam int IDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;

  logic [3:0]         region;
  logic [4:0]         slot;
  logic               aligned;
  logic               in_range;
  logic [IDX_W-1:0]   idx;
  logic               sys_wr;
  logic               sys_run_q;
  logic               bulk_clr;
  logic [NUM_CNT-1:0] wmask;
  logic [NUM_CNT-1:0] run_set, run_clr, ie_set, ie_clr, ovf_clr;
  logic [NUM_CNT-1:0] run_q, ie_q, ovf_q, wrap;
  logic [NUM_CNT-1:0] wr_cnt, wr_sel, wr_ctrl;
  logic [CNT_W-1:0]   cnt_q  [NUM_CNT];
  logic [SEL_W-1:0]   sel_q  [NUM_CNT];
  logic [CTRL_W-1:0]  ctrl_q [NUM_CNT];

  // address decode
  always_comb begin
    region   = addr_i[11:8];
    slot     = addr_i[7:3];
    aligned  = (addr_i[2:0] == 3'b000);
    in_range = int'(slot) < NUM_CNT;
    idx      = slot[IDX_W-1:0];
    wmask    = wdata_i[NUM_CNT-1:0];
    sys_wr   = wr_en_i && aligned && (region == RGN_SYS);
    bulk_clr = sys_wr && (slot == SLOT_SYSW) && wdata_i[1];
    run_set  = (sys_wr && slot == SLOT_RUNS) ? wmask : '0;
    run_clr  = (sys_wr && slot == SLOT_RUNC) ? wmask : '0;
    ie_set   = (sys_wr && slot == SLOT_IES)  ? wmask : '0;
    ie_clr   = (sys_wr && slot == SLOT_IEC)  ? wmask : '0;
    ovf_clr  = (sys_wr && slot == SLOT_OVF)  ? wmask : '0;
  end

  // system run bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            sys_run_q <= 1'b0;
    else if (sys_wr && slot == SLOT_SYSW) sys_run_q <= wdata_i[0];
  end

  for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
    always_comb begin
      wr_cnt[n]  = wr_en_i && aligned && (int'(slot) == n) && (region == RGN_COUNT);
      wr_sel[n]  = wr_en_i && aligned && (int'(slot) == n) && (region == RGN_SEL);
      wr_ctrl[n] = wr_en_i && aligned && (int'(slot) == n) && (region == RGN_CTRL);
    end

    evc_counter #(.CNT_W(CNT_W), .EV_W(EV_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .sys_run_i  (sys_run_q),
      .run_i      (run_q[n]),
      .bulk_clr_i (bulk_clr),
      .events_i   (events_i),
      .wr_cnt_i   (wr_cnt[n]),
      .wr_sel_i   (wr_sel[n]),
      .wr_ctrl_i  (wr_ctrl[n]),
      .wdata_i    (wdata_i[CNT_W-1:0]),
      .cnt_o      (cnt_q[n]),
      .sel_o      (sel_q[n]),
      .ctrl_o     (ctrl_q[n]),
      .wrap_o     (wrap[n])
    );
  end

  evc_bitmap #(.W(NUM_CNT)) u_run (
    .clk(clk), .rst_n(rst_n), .set_i(run_set), .clr_i(run_clr), .q_o(run_q));
  evc_bitmap #(.W(NUM_CNT)) u_ie (
    .clk(clk), .rst_n(rst_n), .set_i(ie_set), .clr_i(ie_clr), .q_o(ie_q));
  evc_bitmap #(.W(NUM_CNT)) u_ovf (
    .clk(clk), .rst_n(rst_n), .set_i(wrap), .clr_i(ovf_clr), .q_o(ovf_q));

  assign irq_o = |(ovf_q & ie_q);

  // read mux
  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      unique case (region)
        RGN_COUNT: if (in_range) rdata_o[CNT_W-1:0]  = cnt_q[idx];
        RGN_CTRL:  if (in_range) rdata_o[CTRL_W-1:0] = ctrl_q[idx];
        RGN_SEL:   if (in_range) rdata_o[SEL_W-1:0]  = sel_q[idx];
        RGN_SYS: begin
          unique case (slot)
            SLOT_SYSW:           rdata_o[0]           = sys_run_q;
            SLOT_RUNS, SLOT_RUNC: rdata_o[NUM_CNT-1:0] = run_q;
            SLOT_IES, SLOT_IEC:   rdata_o[NUM_CNT-1:0] = ie_q;
            SLOT_OVF:            rdata_o[NUM_CNT-1:0] = ovf_q;
            default:             rdata_o = '0;
          endcase
        end
        default: rdata_o = '0;
      endcase
    end
  end

  // R8: a rollover is visible in the overflow bitmap one edge later
  a_r8_wrap_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap != '0) |=> ((ovf_q & $past(wrap)) == $past(wrap)));
  // R4: with the system run bit low no counter rolls over
  a_r4_no_wrap_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_run_q |-> (wrap == '0));
endmodule

// File: tb/test_evcnt_unit.sv
module test_evcnt_unit;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [11:0] addr;
  logic [63:0] wdata;
  logic [63:0] rdata;
  logic [15:0] events;
  logic        irq;
  int checks;
  int errors;
  int cyc;

  evcnt_unit i_evcnt_unit (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .events_i(events), .irq_o(irq));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [11:0] a;
    logic [63:0] d;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h008, 64'h0123456789ABCDEF, 8'd2},   // R2 write counter 1
    '{1'b0, 12'h008, 64'h0123456789ABCDEF, 8'd2},   // R2 read back
    '{1'b1, 12'h038, 64'hFFFF0000FFFF0000, 8'd2},   // R2 counter 7
    '{1'b0, 12'h038, 64'hFFFF0000FFFF0000, 8'd2},
    '{1'b0, 12'h300, 64'h0, 8'd2},                  // R2 unmapped region
    '{1'b0, 12'h404, 64'h0, 8'd2},                  // R2 misaligned
    '{1'b0, 12'h040, 64'h0, 8'd2},                  // R2 slot 8 in counter region
    '{1'b1, 12'h208, 64'h0000000000001234, 8'd3},   // R3 selector width
    '{1'b0, 12'h208, 64'h34, 8'd3},
    '{1'b1, 12'h108, 64'hA5, 8'd11},                // R11 control word
    '{1'b0, 12'h108, 64'hA5, 8'd11},
    '{1'b1, 12'h108, 64'h0, 8'd11},
    '{1'b0, 12'h108, 64'h0, 8'd11},
    '{1'b1, 12'h410, 64'h05, 8'd5},                 // R5 set bits
    '{1'b0, 12'h418, 64'h05, 8'd5},
    '{1'b1, 12'h410, 64'h02, 8'd5},
    '{1'b0, 12'h410, 64'h07, 8'd5},
    '{1'b1, 12'h418, 64'h04, 8'd5},                 // R5 clear one bit
    '{1'b1, 12'h418, 64'h00, 8'd5},                 // R5 zero write no effect
    '{1'b0, 12'h410, 64'h03, 8'd5},
    '{1'b1, 12'h420, 64'h81, 8'd6},                 // R6 interrupt enables
    '{1'b0, 12'h428, 64'h81, 8'd6},
    '{1'b1, 12'h428, 64'h80, 8'd6},
    '{1'b0, 12'h420, 64'h01, 8'd6},
    '{1'b1, 12'h418, 64'hFF, 8'd5},                 // R5 clear all
    '{1'b0, 12'h410, 64'h00, 8'd5},
    '{1'b1, 12'h428, 64'hFF, 8'd6},
    '{1'b0, 12'h420, 64'h00, 8'd6},
    '{1'b0, 12'h440, 64'h00, 8'd9},
    '{1'b0, 12'h400, 64'h00, 8'd7}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [63:0] exp, input string tag);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      finish_run();
    end
  end

  initial begin
    checks = 0; errors = 0; cyc = 0;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; events = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(12'h000, 64'h0, "R1 counter0");
    rd(12'h038, 64'h0, "R1 counter7");
    rd(12'h200, 64'h0, "R1 selector");
    rd(12'h100, 64'h0, "R1 control");
    rd(12'h400, 64'h0, "R1 system");
    rd(12'h410, 64'h0, "R1 run map");
    rd(12'h420, 64'h0, "R1 irq enable map");
    rd(12'h440, 64'h0, "R1 overflow map");
    check("R1 irq", {63'b0, irq}, 64'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr(VECS[i].a, VECS[i].d);
      else rd(VECS[i].a, VECS[i].d, $sformatf("R%0d vector %0d", VECS[i].req, i));
    end
    @(negedge clk);

    // R4: run bit on, system bit off -> no counting
    wr(12'h000, 64'h0);
    wr(12'h410, 64'h1);
    repeat (5) @(negedge clk);
    rd(12'h000, 64'h0, "R4 system off");

    // R3 code 0 counts every cycle: M=4 waits -> 5 increments
    wr(12'h400, 64'h1);
    repeat (4) @(negedge clk);
    wr(12'h400, 64'h0);
    rd(12'h000, 64'd5, "R3 cycle count");
    repeat (3) @(negedge clk);
    rd(12'h000, 64'd5, "R7 stop keeps value");

    // R12 write beats increment
    wr(12'h400, 64'h1);
    wr(12'h000, 64'd100);
    wr(12'h400, 64'h0);
    rd(12'h000, 64'd101, "R12 write priority");

    // R7 bulk zero beats increment
    wr(12'h400, 64'h1);
    wr(12'h400, 64'h3);
    wr(12'h400, 64'h0);
    rd(12'h000, 64'd1, "R7 bulk zero counter0");
    rd(12'h008, 64'd0, "R7 bulk zero counter1");
    rd(12'h038, 64'd0, "R7 bulk zero counter7");

    // R3 event strobe select
    wr(12'h418, 64'h1);
    wr(12'h208, 64'h3);
    wr(12'h410, 64'h2);
    wr(12'h400, 64'h1);
    begin
      logic [9:0] pat;
      pat = 10'b1011001110;
      for (int i = 0; i < 10; i++) begin
        events = 16'h0001;
        events[2] = pat[i];
        @(negedge clk);
      end
    end
    events = '0;
    wr(12'h400, 64'h0);
    rd(12'h008, 64'd6, "R3 strobe count");
    wr(12'h208, 64'h40);
    wr(12'h400, 64'h1);
    events = 16'hFFFF;
    repeat (5) @(negedge clk);
    events = '0;
    wr(12'h400, 64'h0);
    rd(12'h008, 64'd6, "R3 unused code");

    // R8 / R10 rollover and interrupt
    wr(12'h418, 64'hFF);
    wr(12'h010, 64'hFFFFFFFFFFFFFFFD);
    wr(12'h210, 64'h0);
    wr(12'h420, 64'h4);
    wr(12'h410, 64'h4);
    wr(12'h400, 64'h1);
    repeat (4) @(negedge clk);
    wr(12'h400, 64'h0);
    rd(12'h010, 64'd2, "R8 continues after wrap");
    rd(12'h440, 64'h4, "R8 overflow flag");
    check("R10 irq high", {63'b0, irq}, 64'h1);
    wr(12'h428, 64'h4);
    check("R10 irq masked", {63'b0, irq}, 64'h0);
    rd(12'h440, 64'h4, "R10 flag kept while masked");
    wr(12'h420, 64'h4);
    check("R10 irq unmasked", {63'b0, irq}, 64'h1);
    wr(12'h440, 64'hFB);
    rd(12'h440, 64'h4, "R9 other bits only");
    wr(12'h440, 64'h4);
    rd(12'h440, 64'h0, "R9 write one clears");
    check("R10 irq after clear", {63'b0, irq}, 64'h0);

    // R9 rollover and clear on the same edge
    wr(12'h418, 64'h4);
    wr(12'h018, 64'hFFFFFFFFFFFFFFFF);
    wr(12'h218, 64'h0);
    wr(12'h410, 64'h8);
    wr(12'h400, 64'h1);
    wr(12'h440, 64'h8);
    wr(12'h400, 64'h0);
    rd(12'h440, 64'h8, "R9 set wins");
    rd(12'h018, 64'd1, "R8 wrap then count");

    finish_run();
  end
endmodule